// File: doc/BRIEF.md
# Token-Passing Ring Access Controller

This block decides when one node of a token-passing ring may transmit, and to whom. It has up to 31 participants, each with a 5-bit ID. The controller keeps the node's logical neighbour, which is the next ID that answered a token. It receives tokens and either passes them on or runs a short exchange first. That exchange is a free-buffer enquiry, then a data packet on acknowledge. When the ring goes silent, the controller rebuilds it. It waits for a priority interval that grows with the distance between its own ID and the configured maximum ID. Then it hunts for a neighbour by sending tokens to rising IDs until one of them answers.

The node whose ID equals the maximum ID has a zero priority interval. It starts at once with a token to ID 0. No node takes that token, but its line activity pulls every other node out of its priority wait. All intervals are counted in bit-rate ticks, so one set of limits serves any line speed. Frame decoding is done outside the block, and the results arrive as single-cycle strobes. The block answers with single-cycle send requests that carry a destination ID.

Top module: `ring_token_mac`

## Requirements
- R1: While reset is asserted and right after it is released, no send request is raised, and the destination and neighbour outputs read 0. After reset the node starts in the priority wait of a reconfiguration.
- R2: A valid node that sees no line activity sends its first token after (emax − own ID) × PRIO_UNIT ticks of the priority wait. The request appears on the cycle after the edge where the count reaches that limit. Here emax is the effective maximum ID.
- R3: A node whose own ID equals emax has a zero priority interval. It sends a token to destination 0 on the first cycle after reset.
- R4: A line activity strobe during the priority wait cancels it, and the node returns to listening without sending.
- R5: The neighbour search starts at own ID + 1. After each response window of RESP_BITS + 1 ticks with no line activity, the destination advances by one. After emax, the destination wraps to 0, so no token ever goes to an ID above emax.
- R6: With retry enabled, every destination in the search gets its token twice before the node advances. With retry disabled, the node advances after every window.
- R7: Line activity during a response window stores the current destination as the neighbour. The next token-for-me strobe is passed to that neighbour two cycles later, unless a send is pending.
- R8: If a send is pending when the token arrives, the node issues an enquiry to the requested ID. On acknowledge, it requests the data packet to that ID on the next cycle and then passes the token. On negative acknowledge, it passes the token without a packet. At most one request is raised per cycle.
- R9: A corrupted reply to an enquiry passes the token when recovery is enabled. When recovery is disabled, the node drops back to listening without sending anything.
- R10: An enquiry that draws no reply within the response window is followed by a token pass.
- R11: An own ID of 0, or an own ID above emax, keeps the node silent. It ignores tokens and raises no request.
- R12: With the diagnostic input high, emax is 31 whatever the maximum-ID input says. This affects both the priority interval and the search wrap point.
- R13: While listening, LOSS_BITS + 1 ticks without line activity or a token cause a new priority wait, and after it a neighbour search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per bit time |
| my_id_i | input | 5 | Own node ID |
| max_id_i | input | 5 | Highest ID in the ring |
| diag_i | input | 1 | Forces the effective maximum ID to 31 |
| retry_en_i | input | 1 | Send each search token twice |
| ack_fix_en_i | input | 1 | Pass the token after a corrupted enquiry reply |
| line_act_i | input | 1 | Activity from another node seen on the line |
| tok_me_i | input | 1 | A token addressed to this node was received |
| ack_i | input | 1 | Acknowledge received |
| nak_i | input | 1 | Negative acknowledge received |
| bad_i | input | 1 | Corrupted frame received |
| tx_req_i | input | 1 | Data is waiting to be sent |
| tx_req_dst_i | input | 5 | Destination for the waiting data |
| tx_token_o | output | 1 | Send-token request |
| tx_enq_o | output | 1 | Send-enquiry request |
| tx_pkt_o | output | 1 | Send-packet request |
| tx_dst_o | output | 5 | Destination of the last request (held between requests) |
| nbr_id_o | output | 5 | Current logical neighbour |

## Verification
Every request is registered. It appears on the cycle after the edge that decides it. A token-for-me strobe leads to a token pass or an enquiry two cycles later, and an acknowledge leads to the packet request one cycle later. Timed events come one tick after their count limit is reached. That is (emax − ID) × PRIO_UNIT + 1 ticks for the first token and RESP_BITS + 1 ticks per search step. The bench drives inputs on falling edges and steps a behavioural reference on rising edges. At every falling edge it compares all outputs with the reference. It also counts the cycles from reset release to the first token and checks that count against these formulas.

// File: rtl/ring_mac_pkg.sv
package ring_mac_pkg;
  localparam int ID_W = 5;

  typedef logic [ID_W-1:0] node_id_t;

  typedef enum logic [2:0] {
    ST_LISTEN,
    ST_PRIO,
    ST_HOLD,
    ST_PASS,
    ST_WRESP,
    ST_WACK
  } mac_st_e;

  // successor inside the ring 0..top
  function automatic node_id_t id_succ(node_id_t cur, node_id_t top);
    return (cur >= top) ? '0 : node_id_t'(cur + node_id_t'(1));
  endfunction
endpackage

// File: rtl/ring_id_cfg.sv
module ring_id_cfg
  import ring_mac_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int PRIO_UNIT = 365
) (
  input  logic [ID_W-1:0]  my_id_i,
  input  logic [ID_W-1:0]  max_id_i,
  input  logic             diag_i,
  output logic [ID_W-1:0]  eff_max_o,
  output logic             id_ok_o,
  output logic [ID_W-1:0]  first_dst_o,
  output logic [CNT_W-1:0] prio_lim_o
);
  logic [ID_W-1:0] gap;

  always_comb begin
    eff_max_o   = diag_i ? '1 : max_id_i;
    id_ok_o     = (my_id_i != '0) && (my_id_i <= eff_max_o);
    first_dst_o = id_succ(my_id_i, eff_max_o);
    gap         = eff_max_o - my_id_i;
    prio_lim_o  = CNT_W'(gap) * CNT_W'(PRIO_UNIT);
  end
endmodule

// File: rtl/ring_timer.sv
module ring_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clr_i)                        cnt_q <= '0;
    else if (tick_i && !expired_o)         cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/ring_mac_fsm.sv
module ring_mac_fsm
  import ring_mac_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int RESP_BITS = 195,
  parameter int LOSS_BITS = 2100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             id_ok_i,
  input  logic [ID_W-1:0]  eff_max_i,
  input  logic [ID_W-1:0]  first_dst_i,
  input  logic [CNT_W-1:0] prio_lim_i,
  input  logic             retry_en_i,
  input  logic             ack_fix_en_i,
  input  logic             line_act_i,
  input  logic             tok_me_i,
  input  logic             ack_i,
  input  logic             nak_i,
  input  logic             bad_i,
  input  logic             tx_req_i,
  input  logic [ID_W-1:0]  tx_req_dst_i,
  input  logic             expired_i,
  output logic             clr_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             tx_token_o,
  output logic             tx_enq_o,
  output logic             tx_pkt_o,
  output logic [ID_W-1:0]  tx_dst_o,
  output logic [ID_W-1:0]  nbr_id_o
);
  mac_st_e         st_q, st_d;
  logic            tok_q, tok_d, enq_q, enq_d, pkt_q, pkt_d;
  logic            ret_q, ret_d;
  logic [ID_W-1:0] dst_q, dst_d, cand_q, cand_d, nbr_q, nbr_d, lat_q, lat_d;

  always_comb begin
    unique case (st_q)
      ST_LISTEN: limit_o = CNT_W'(LOSS_BITS);
      ST_PRIO:   limit_o = prio_lim_i;
      default:   limit_o = CNT_W'(RESP_BITS);
    endcase
  end

  always_comb begin
    st_d   = st_q;
    clr_o  = 1'b0;
    tok_d  = 1'b0;
    enq_d  = 1'b0;
    pkt_d  = 1'b0;
    dst_d  = dst_q;
    cand_d = cand_q;
    ret_d  = ret_q;
    nbr_d  = nbr_q;
    lat_d  = lat_q;
    if (!id_ok_i) begin
      st_d  = ST_LISTEN;
      clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_LISTEN: begin
          if (tok_me_i) begin
            st_d  = ST_HOLD;
            clr_o = 1'b1;
          end else if (line_act_i) begin
            clr_o = 1'b1;
          end else if (expired_i) begin
            st_d  = ST_PRIO;
            clr_o = 1'b1;
          end
        end
        ST_PRIO: begin
          if (line_act_i) begin
            st_d  = ST_LISTEN;
            clr_o = 1'b1;
          end else if (expired_i) begin
            cand_d = first_dst_i;
            dst_d  = first_dst_i;
            tok_d  = 1'b1;
            ret_d  = 1'b0;
            st_d   = ST_WRESP;
            clr_o  = 1'b1;
          end
        end
        ST_WRESP: begin
          if (line_act_i) begin
            nbr_d = cand_q;
            st_d  = ST_LISTEN;
            clr_o = 1'b1;
          end else if (expired_i) begin
            if (retry_en_i && !ret_q) begin
              ret_d = 1'b1;
              dst_d = cand_q;
            end else begin
              cand_d = id_succ(cand_q, eff_max_i);
              dst_d  = id_succ(cand_q, eff_max_i);
              ret_d  = 1'b0;
            end
            tok_d = 1'b1;
            clr_o = 1'b1;
          end
        end
        ST_HOLD, ST_PASS: begin
          if (st_q == ST_HOLD && tx_req_i) begin
            enq_d = 1'b1;
            dst_d = tx_req_dst_i;
            lat_d = tx_req_dst_i;
            st_d  = ST_WACK;
          end else begin
            tok_d  = 1'b1;
            dst_d  = nbr_q;
            cand_d = nbr_q;
            ret_d  = 1'b0;
            st_d   = ST_WRESP;
          end
          clr_o = 1'b1;
        end
        ST_WACK: begin
          if (ack_i) begin
            pkt_d = 1'b1;
            dst_d = lat_q;
            st_d  = ST_PASS;
            clr_o = 1'b1;
          end else if (nak_i) begin
            st_d  = ST_PASS;
            clr_o = 1'b1;
          end else if (bad_i) begin
            st_d  = ack_fix_en_i ? ST_PASS : ST_LISTEN;
            clr_o = 1'b1;
          end else if (expired_i) begin
            st_d  = ST_PASS;
            clr_o = 1'b1;
          end
        end
        default: begin
          st_d  = ST_LISTEN;
          clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PRIO;
      tok_q  <= 1'b0;
      enq_q  <= 1'b0;
      pkt_q  <= 1'b0;
      ret_q  <= 1'b0;
      dst_q  <= '0;
      cand_q <= '0;
      nbr_q  <= '0;
      lat_q  <= '0;
    end else begin
      st_q   <= st_d;
      tok_q  <= tok_d;
      enq_q  <= enq_d;
      pkt_q  <= pkt_d;
      ret_q  <= ret_d;
      dst_q  <= dst_d;
      cand_q <= cand_d;
      nbr_q  <= nbr_d;
      lat_q  <= lat_d;
    end
  end

  assign tx_token_o = tok_q;
  assign tx_enq_o   = enq_q;
  assign tx_pkt_o   = pkt_q;
  assign tx_dst_o   = dst_q;
  assign nbr_id_o   = nbr_q;

  assert_single_tx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tok_q, enq_q, pkt_q}));

  assert_quiet_invalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_ok_i |=> !(tok_q || enq_q || pkt_q));

  assert_nbr_on_reply_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nbr_q) |-> $past(line_act_i));

  assert_prio_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_ok_i && st_q == ST_PRIO && line_act_i) |=> (st_q == ST_LISTEN && !tok_q));

  assert_hold_no_fix_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_ok_i && st_q == ST_WACK && bad_i && !ack_i && !nak_i && !ack_fix_en_i)
    |=> (st_q == ST_LISTEN && !tok_q));
endmodule

// File: rtl/ring_token_mac.sv
module ring_token_mac
  import ring_mac_pkg::*;
#(
  parameter int PRIO_UNIT = 365,
  parameter int RESP_BITS = 195,
  parameter int LOSS_BITS = 2100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [ID_W-1:0] my_id_i,
  input  logic [ID_W-1:0] max_id_i,
  input  logic            diag_i,
  input  logic            retry_en_i,
  input  logic            ack_fix_en_i,
  input  logic            line_act_i,
  input  logic            tok_me_i,
  input  logic            ack_i,
  input  logic            nak_i,
  input  logic            bad_i,
  input  logic            tx_req_i,
  input  logic [ID_W-1:0] tx_req_dst_i,
  output logic            tx_token_o,
  output logic            tx_enq_o,
  output logic            tx_pkt_o,
  output logic [ID_W-1:0] tx_dst_o,
  output logic [ID_W-1:0] nbr_id_o
);
  localparam int PRIO_TOP = ((1 << ID_W) - 1) * PRIO_UNIT;
  localparam int SPAN_A   = (PRIO_TOP > LOSS_BITS) ? PRIO_TOP : LOSS_BITS;
  localparam int SPAN     = (SPAN_A > RESP_BITS) ? SPAN_A : RESP_BITS;
  localparam int CNT_W    = $clog2(SPAN + 1);

  logic [ID_W-1:0]  eff_max, first_dst;
  logic             id_ok, tmr_clr, tmr_exp;
  logic [CNT_W-1:0] prio_lim, tmr_lim;

  ring_id_cfg #(.CNT_W(CNT_W), .PRIO_UNIT(PRIO_UNIT)) u_cfg (
    .my_id_i    (my_id_i),
    .max_id_i   (max_id_i),
    .diag_i     (diag_i),
    .eff_max_o  (eff_max),
    .id_ok_o    (id_ok),
    .first_dst_o(first_dst),
    .prio_lim_o (prio_lim)
  );

  ring_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clr_i    (tmr_clr),
    .limit_i  (tmr_lim),
    .expired_o(tmr_exp)
  );

  ring_mac_fsm #(.CNT_W(CNT_W), .RESP_BITS(RESP_BITS), .LOSS_BITS(LOSS_BITS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_ok_i     (id_ok),
    .eff_max_i   (eff_max),
    .first_dst_i (first_dst),
    .prio_lim_i  (prio_lim),
    .retry_en_i  (retry_en_i),
    .ack_fix_en_i(ack_fix_en_i),
    .line_act_i  (line_act_i),
    .tok_me_i    (tok_me_i),
    .ack_i       (ack_i),
    .nak_i       (nak_i),
    .bad_i       (bad_i),
    .tx_req_i    (tx_req_i),
    .tx_req_dst_i(tx_req_dst_i),
    .expired_i   (tmr_exp),
    .clr_o       (tmr_clr),
    .limit_o     (tmr_lim),
    .tx_token_o  (tx_token_o),
    .tx_enq_o    (tx_enq_o),
    .tx_pkt_o    (tx_pkt_o),
    .tx_dst_o    (tx_dst_o),
    .nbr_id_o    (nbr_id_o)
  );

  assert_dst_in_ring_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_token_o |-> (tx_dst_o <= eff_max));

  assert_diag_wrap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_i && id_ok) |-> (eff_max == '1));
endmodule

// File: tb/ring_token_mac_tb_top.sv
module ring_token_mac_tb_top;
  localparam int UNIT = 365;
  localparam int RESP = 195;
  localparam int LOSS = 2100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [4:0] my = 5'd3, mx = 5'd5, rdst = '0;
  logic diag = 0, ren = 1, fen = 1, la = 0, tme = 0, ack = 0, nak = 0, bad = 0, req = 0;
  logic tok, enq, pkt;
  logic [4:0] dst, nbr;

  int n_chk = 0, n_bad = 0, cyc_n = 0;
  string cur_req = "R1";
  bit tick_sparse = 0;
  int tdiv = 0;

  int tokq[$];
  int enq_cnt = 0, pkt_cnt = 0, last_enq = -1, last_pkt = -1;

  // reference model state
  int m_st, m_cnt, m_cand, m_ret, m_nbr, m_dst, m_lat, m_tok, m_enq, m_pkt;

  always #2 clk = ~clk;

  ring_token_mac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .my_id_i(my), .max_id_i(mx),
    .diag_i(diag), .retry_en_i(ren), .ack_fix_en_i(fen), .line_act_i(la),
    .tok_me_i(tme), .ack_i(ack), .nak_i(nak), .bad_i(bad), .tx_req_i(req),
    .tx_req_dst_i(rdst), .tx_token_o(tok), .tx_enq_o(enq), .tx_pkt_o(pkt),
    .tx_dst_o(dst), .nbr_id_o(nbr)
  );

  always @(negedge clk) begin
    if (tick_sparse) begin
      tick <= (tdiv == 0);
      tdiv <= (tdiv + 1) % 4;
    end else begin
      tick <= 1'b1;
    end
  end

  // 0 listen, 1 prio, 2 hold, 3 pass, 4 wait reply, 5 wait ack
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 1; m_cnt = 0; m_cand = 0; m_ret = 0; m_nbr = 0;
      m_dst = 0; m_lat = 0; m_tok = 0; m_enq = 0; m_pkt = 0;
    end else begin
      int emax, lim;
      bit ok, pass;
      emax = diag ? 31 : int'(mx);
      ok = (my != 0) && (int'(my) <= emax);
      m_tok = 0; m_enq = 0; m_pkt = 0; pass = 0;
      if (!ok) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        if (tme) begin m_st = 2; m_cnt = 0; end
        else if (la) m_cnt = 0;
        else if (m_cnt >= LOSS) begin m_st = 1; m_cnt = 0; end
        else if (tick) m_cnt++;
      end else if (m_st == 1) begin
        lim = (emax - int'(my)) * UNIT;
        if (la) begin m_st = 0; m_cnt = 0; end
        else if (m_cnt >= lim) begin
          m_cand = (int'(my) >= emax) ? 0 : int'(my) + 1;
          m_dst = m_cand; m_tok = 1; m_ret = 0; m_st = 4; m_cnt = 0;
        end else if (tick) m_cnt++;
      end else if (m_st == 4) begin
        if (la) begin m_nbr = m_cand; m_st = 0; m_cnt = 0; end
        else if (m_cnt >= RESP) begin
          if (ren && m_ret == 0) m_ret = 1;
          else begin m_cand = (m_cand >= emax) ? 0 : m_cand + 1; m_ret = 0; end
          m_dst = m_cand; m_tok = 1; m_cnt = 0;
        end else if (tick) m_cnt++;
      end else if (m_st == 2) begin
        if (req) begin m_enq = 1; m_dst = int'(rdst); m_lat = int'(rdst); m_st = 5; m_cnt = 0; end
        else pass = 1;
      end else if (m_st == 3) begin
        pass = 1;
      end else begin
        if (ack) begin m_pkt = 1; m_dst = m_lat; m_st = 3; end
        else if (nak) m_st = 3;
        else if (bad) begin m_st = fen ? 3 : 0; m_cnt = 0; end
        else if (m_cnt >= RESP) m_st = 3;
        else if (tick) m_cnt++;
      end
      if (pass) begin
        m_tok = 1; m_dst = m_nbr; m_cand = m_nbr; m_ret = 0; m_st = 4; m_cnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (tok) tokq.push_back(int'(dst));
    if (enq) begin enq_cnt++; last_enq = int'(dst); end
    if (pkt) begin pkt_cnt++; last_pkt = int'(dst); end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (int'(tok) != m_tok || int'(enq) != m_enq || int'(pkt) != m_pkt ||
          int'(dst) != m_dst || int'(nbr) != m_nbr) begin
        n_bad++;
        $display("FAIL %s t=%0t: actual tok%0d enq%0d pkt%0d dst%0d nbr%0d expected tok%0d enq%0d pkt%0d dst%0d nbr%0d",
                 cur_req, $time, tok, enq, pkt, dst, nbr, m_tok, m_enq, m_pkt, m_dst, m_nbr);
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_n);
      report();
      $finish;
    end
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int seen(int which);
    if (which == 0) return tokq.size();
    if (which == 1) return enq_cnt;
    return pkt_cnt;
  endfunction

  // advance falling edges until count of kind 'which' reaches target
  task automatic wait_for(int which, int target, int lim, output int n);
    n = 0;
    while (seen(which) < target && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset(int id, int top, bit dg, bit re, bit fe);
    @(negedge clk);
    #1 rst_n = 0;
    my = 5'(id); mx = 5'(top); diag = dg; ren = re; fen = fe;
    la = 0; tme = 0; ack = 0; nak = 0; bad = 0; req = 0;
    repeat (3) @(negedge clk);
    tokq.delete(); enq_cnt = 0; pkt_cnt = 0;
    rst_n = 1;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic tok_in();
    tme = 1; la = 1; @(negedge clk); tme = 0; la = 0;
  endtask

  initial begin
    int n, t0, e0, p0;
    // R1 / R2 / R5 / R6
    do_reset(3, 5, 0, 1, 1);
    cur_req = "R1";
    chk("R1 token idle", int'(tok), 0);
    chk("R1 nbr", int'(nbr), 0);
    chk("R1 dst", int'(dst), 0);
    cur_req = "R2";
    wait_for(0, 1, 3000, n);
    chk("R2 first token delay", n, 2 * UNIT + 1);
    chk("R5 first search dst", tokq[0], 4);
    cur_req = "R6";
    wait_for(0, 6, 3000, n);
    chk("R6 retry 4", tokq[1], 4);
    chk("R5 step 5", tokq[2], 5);
    chk("R6 retry 5", tokq[3], 5);
    chk("R5 wrap 0", tokq[4], 0);
    chk("R6 retry 0", tokq[5], 0);
    // R7: answer when destination 1 is tried
    cur_req = "R7";
    while (!(tok && dst == 5'd1)) @(negedge clk);
    pulse(la);
    chk("R7 nbr stored", int'(nbr), 1);
    t0 = tokq.size();
    tok_in();
    wait_for(0, t0 + 1, 5, n);
    chk("R7 pass to nbr", tokq[$], 1);
    pulse(la);
    // R8 ack path
    cur_req = "R8";
    req = 1; rdst = 5'd2; e0 = enq_cnt;
    tok_in();
    wait_for(1, e0 + 1, 5, n);
    chk("R8 enquiry dst", last_enq, 2);
    req = 0; p0 = pkt_cnt; t0 = tokq.size();
    pulse(ack);
    wait_for(2, p0 + 1, 3, n);
    chk("R8 packet dst", last_pkt, 2);
    wait_for(0, t0 + 1, 3, n);
    chk("R8 pass after packet", tokq[$], 1);
    pulse(la);
    // R8 nak path
    req = 1; rdst = 5'd4; e0 = enq_cnt;
    tok_in();
    wait_for(1, e0 + 1, 5, n);
    req = 0; p0 = pkt_cnt; t0 = tokq.size();
    pulse(nak);
    wait_for(0, t0 + 1, 4, n);
    chk("R8 nak passes token", tokq.size(), t0 + 1);
    chk("R8 nak no packet", pkt_cnt, p0);
    pulse(la);
    // R9 corrupted reply, recovery on
    cur_req = "R9";
    req = 1; e0 = enq_cnt;
    tok_in();
    wait_for(1, e0 + 1, 5, n);
    req = 0; t0 = tokq.size();
    pulse(bad);
    wait_for(0, t0 + 1, 4, n);
    chk("R9 recovery passes", tokq.size(), t0 + 1);
    pulse(la);
    // R10 enquiry timeout
    cur_req = "R10";
    req = 1; e0 = enq_cnt;
    tok_in();
    wait_for(1, e0 + 1, 5, n);
    req = 0; t0 = tokq.size();
    wait_for(0, t0 + 1, 400, n);
    chk("R10 pass after timeout", tokq.size(), t0 + 1);
    pulse(la);
    // R9 recovery off, then R13 loss
    cur_req = "R9";
    fen = 0; req = 1; e0 = enq_cnt;
    tok_in();
    wait_for(1, e0 + 1, 5, n);
    req = 0; t0 = tokq.size();
    pulse(bad);
    repeat (50) @(negedge clk);
    chk("R9 token held", tokq.size(), t0);
    cur_req = "R13";
    wait_for(0, t0 + 1, 4000, n);
    chk("R13 reconfig after silence", tokq.size(), t0 + 1);
    chk("R13 search restarts", tokq[$], 4);
    // R6 retry disabled
    cur_req = "R6";
    do_reset(3, 5, 0, 0, 1);
    wait_for(0, 4, 3000, n);
    chk("R6 no retry a", tokq[0], 4);
    chk("R6 no retry b", tokq[1], 5);
    chk("R6 no retry c", tokq[2], 0);
    chk("R6 no retry d", tokq[3], 1);
    // R3 max node
    cur_req = "R3";
    do_reset(5, 5, 0, 1, 1);
    wait_for(0, 1, 50, n);
    chk("R3 immediate", n, 1);
    chk("R3 to id 0", tokq.size() > 0 ? tokq[0] : -1, 0);
    // R4 cancel
    cur_req = "R4";
    do_reset(3, 5, 0, 1, 1);
    for (int i = 0; i < 10; i++) begin
      repeat (300) @(negedge clk);
      pulse(la);
    end
    chk("R4 no token", tokq.size(), 0);
    // R11 invalid IDs
    cur_req = "R11";
    do_reset(0, 5, 0, 1, 1);
    req = 1;
    for (int i = 0; i < 20; i++) begin
      repeat (100) @(negedge clk);
      tok_in();
    end
    chk("R11 id0 silent", tokq.size() + enq_cnt, 0);
    do_reset(7, 5, 0, 1, 1);
    req = 1;
    for (int i = 0; i < 20; i++) begin
      repeat (100) @(negedge clk);
      tok_in();
    end
    chk("R11 id above max silent", tokq.size() + enq_cnt, 0);
    // R12 diagnostic
    cur_req = "R12";
    do_reset(3, 5, 1, 0, 1);
    wait_for(0, 1, 12000, n);
    chk("R12 prio uses 31", n, 28 * UNIT + 1);
    wait_for(0, 29, 8000, n);
    chk("R12 reaches 31", tokq.size() > 28 ? tokq[27] : -1, 31);
    chk("R12 wraps to 0", tokq.size() > 28 ? tokq[28] : -1, 0);
    // R2 with sparse ticks
    cur_req = "R2";
    tick_sparse = 1;
    do_reset(4, 5, 0, 1, 1);
    wait_for(0, 1, 3000, n);
    chk("R2 tick-scaled delay", int'(n >= 1455 && n <= 1470), 1);
    chk("R2 first dst", tokq.size() > 0 ? tokq[0] : -1, 5);
    tick_sparse = 0;
    repeat (5) @(negedge clk);
    report();
    $finish;
  end
endmodule